// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block holds the control register of a CAN controller and walks the controller between its four operating modes: sleep, reset, halt and operation. Software writes a requested mode into the control register. The block moves to that mode once the move's completion condition is met, and it reports the mode it is in through a status register that software can poll.

A forced reset completes after a fixed number of cycles. A normal reset or halt request waits until the bus is idle. Returning to operation completes after a fixed settling delay. When automatic recovery is selected, a bus-off event sends the block straight into halt. The bit-configuration register and the mode-select bits of the control register accept writes only while the block is in reset. A sleep request takes effect only from halt or reset.

Top module: `can_mode_ctrl`

## Requirements
- R1: After hardware reset the block is in sleep: the control register reads 0x0500 (sleep bit 10 set, mode field 9:8 = 01), the status register reads 0x0400, and the bit-configuration register reads 0.
- R2: In sleep, a control write that clears bit 10 moves the block to reset on the first clock edge after the edge that captured the write.
- R3: Mode field 11 (forced reset) moves the block to reset FORCE_DLY clock edges after the write edge, whatever the bus-idle input is doing.
- R4: Mode field 01 (reset) or 10 (halt) completes on the first clock edge after the write edge at which bus_idle is high. Until then the block stays in its current mode.
- R5: Mode field 00 (operation) requested from reset completes OPER_DLY clock edges after the write edge. Status bit 8 stays 1 until that edge and reads 0 after it.
- R6: When the recovery field (bits 12:11) is 01 and the block is in operation, a bus_off pulse moves it to halt on that clock edge and the mode field reads 10 afterwards. With any other recovery value, bus_off has no effect.
- R7: Writes to the bit-configuration register, to the recovery field and to bits 3:0 of the control register (bit 3 overrun mode, bits 2:1 ID format, bit 0 FIFO mailbox mode) take effect only in reset and are ignored in every other mode.
- R8: The sleep bit is stored only when the block is in halt, reset or sleep. In halt or reset, storing it moves the block to sleep one edge later. Written in operation, it reads 0 and the block stays in operation.
- R9: Status bit 8 is set in reset, bit 9 in halt and bit 10 in sleep, and every other status bit is 0. Exactly one of the four mode outputs is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 16 | Control register write data |
| cfg_wr_en | input | 1 | Bit-configuration register write strobe |
| cfg_wr_data | input | CFG_W | Bit-configuration write data |
| bus_idle | input | 1 | Bus is idle, so a normal mode change may complete |
| bus_off | input | 1 | One-cycle bus-off event from the protocol engine |
| ctl_q | output | 16 | Control register contents |
| stat_q | output | 16 | Status register |
| cfg_q | output | CFG_W | Bit-configuration register contents |
| mode_sleep | output | 1 | Block is in sleep |
| mode_reset | output | 1 | Block is in reset |
| mode_halt | output | 1 | Block is in halt |
| mode_oper | output | 1 | Block is in operation |

## Verification
Every result is counted in clock edges from the edge that captures a control write. A write, a sleep exit or a sleep entry shows one edge later. A forced reset shows FORCE_DLY edges later and a move to operation OPER_DLY edges later. A bus-off halt shows on the edge that samples the pulse, and an idle-gated change on the first sampled edge with bus_idle high. Each table row drives its inputs on a falling edge, lets the write edge plus a stated number of further edges pass, and samples on the following falling edge. Some rows sample one edge before a delayed change is due and the next row samples on the edge where it lands, which pins each delay to the exact edge.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    OM_OPER  = 2'd0,
    OM_RESET = 2'd1,
    OM_HALT  = 2'd2,
    OM_SLEEP = 2'd3
  } opmode_e;

  // mode field request codes (control bits 9:8)
  localparam logic [1:0] MF_OPER  = 2'b00;
  localparam logic [1:0] MF_RESET = 2'b01;
  localparam logic [1:0] MF_HALT  = 2'b10;
  localparam logic [1:0] MF_FORCE = 2'b11;

  // recovery field value that halts on bus-off (control bits 12:11)
  localparam logic [1:0] REC_AUTO_HALT = 2'b01;

  typedef struct packed {
    logic [2:0] rsv_hi;
    logic [1:0] recov;
    logic       sleep;
    logic [1:0] mode;
    logic [3:0] rsv_mid;
    logic       ovr_mode;
    logic [1:0] id_fmt;
    logic       fifo_mb;
  } ctl_t;

  localparam logic [15:0] CTL_RST_VAL  = 16'h0500;
  localparam logic [15:0] MSK_MODE     = 16'h0300;
  localparam logic [15:0] MSK_SLEEP    = 16'h0400;
  localparam logic [15:0] MSK_LOCKED   = 16'h180F;

  localparam int STAT_W = 16;

  function automatic opmode_e mode_goal(input logic [1:0] f);
    case (f)
      MF_OPER: mode_goal = OM_OPER;
      MF_HALT: mode_goal = OM_HALT;
      default: mode_goal = OM_RESET;
    endcase
  endfunction

endpackage

// File: rtl/can_mode_regs.sv
module can_mode_regs
  import can_mode_pkg::*;
#(
  parameter int CFG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [15:0]      ctl_wr_data,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  opmode_e          cur_mode,
  input  logic             auto_halt,
  output ctl_t             ctl,
  output logic [CFG_W-1:0] cfg_q
);

  logic [15:0]      ctl_q, ctl_d, wr_mask, wr_eff;
  logic             ctl_en, cfg_en, sleep_ok, unlocked;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    unlocked = (cur_mode == OM_RESET);
    sleep_ok = (cur_mode != OM_OPER);
    wr_mask  = MSK_MODE | MSK_SLEEP | (unlocked ? MSK_LOCKED : 16'h0000);
    wr_eff   = ctl_wr_data & ~(sleep_ok ? 16'h0000 : MSK_SLEEP);
    ctl_d    = ctl_q;
    if (ctl_wr_en) ctl_d = (ctl_q & ~wr_mask) | (wr_eff & wr_mask);
    if (auto_halt) ctl_d[9:8] = MF_HALT;
    ctl_en   = ctl_wr_en | auto_halt;
    cfg_en   = cfg_wr_en & unlocked;
    cfg_d    = cfg_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST_VAL;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign ctl = ctl_t'(ctl_q);

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cur_mode != OM_RESET) |=> $stable(cfg_q)); // R7

  AST_SLEEP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && cur_mode == OM_OPER) |=> !ctl_q[10]); // R8

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
#(
  parameter int FORCE_DLY = 2,
  parameter int OPER_DLY  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       sleep_req,
  input  logic [1:0] recov,
  input  logic       wr_seen,
  input  logic       bus_idle,
  input  logic       bus_off,
  output opmode_e    cur_mode,
  output logic       auto_halt
);

  localparam int MAXD = (FORCE_DLY > OPER_DLY) ? FORCE_DLY : OPER_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  opmode_e       cur_q, cur_d, goal;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          timed, cnt_en, is_oper;

  always_comb begin
    goal      = mode_goal(mode_req);
    auto_halt = (cur_q == OM_OPER) && bus_off && (recov == REC_AUTO_HALT);
    timed     = (mode_req == MF_FORCE) || (mode_req == MF_OPER);
    lim       = (mode_req == MF_FORCE) ? CW'(FORCE_DLY - 1) : CW'(OPER_DLY - 1);
    cur_d     = cur_q;
    cnt_d     = '0;
    if (cur_q == OM_SLEEP) begin
      if (!sleep_req) cur_d = OM_RESET;
    end else if (auto_halt) begin
      cur_d = OM_HALT;
    end else if (sleep_req && cur_q != OM_OPER) begin
      cur_d = OM_SLEEP;
    end else if (goal != cur_q) begin
      if (timed) begin
        if (cnt_q == lim) cur_d = goal;
        else              cnt_d = cnt_q + 1'b1;
      end else if (bus_idle) begin
        cur_d = goal;
      end
    end
    if (wr_seen) cnt_d = '0;
    cnt_en = wr_seen | (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= OM_SLEEP;
    else        cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cur_mode = cur_q;
  assign is_oper  = (cur_q == OM_OPER);

  AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == OM_OPER && !bus_idle && !auto_halt &&
     (mode_req == MF_RESET || mode_req == MF_HALT)) |=> cur_q == OM_OPER); // R4

  AST_NO_SLEEP_FROM_OPER: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == OM_OPER) |=> cur_q != OM_SLEEP); // R8

  AST_OPER_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_oper) |-> $past(mode_req) == MF_OPER); // R5

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int CFG_W     = 24,
  parameter int FORCE_DLY = 2,
  parameter int OPER_DLY  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [15:0]      ctl_wr_data,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  logic             bus_idle,
  input  logic             bus_off,
  output logic [15:0]      ctl_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [CFG_W-1:0] cfg_q,
  output logic             mode_sleep,
  output logic             mode_reset,
  output logic             mode_halt,
  output logic             mode_oper
);

  ctl_t    ctl;
  opmode_e cur_mode;
  logic    auto_halt;

  can_mode_regs #(.CFG_W(CFG_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cur_mode    (cur_mode),
    .auto_halt   (auto_halt),
    .ctl         (ctl),
    .cfg_q       (cfg_q)
  );

  can_mode_fsm #(.FORCE_DLY(FORCE_DLY), .OPER_DLY(OPER_DLY)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_req  (ctl.mode),
    .sleep_req (ctl.sleep),
    .recov     (ctl.recov),
    .wr_seen   (ctl_wr_en),
    .bus_idle  (bus_idle),
    .bus_off   (bus_off),
    .cur_mode  (cur_mode),
    .auto_halt (auto_halt)
  );

  always_comb begin
    mode_sleep = (cur_mode == OM_SLEEP);
    mode_reset = (cur_mode == OM_RESET);
    mode_halt  = (cur_mode == OM_HALT);
    mode_oper  = (cur_mode == OM_OPER);
    stat_q     = '0;
    stat_q[8]  = mode_reset;
    stat_q[9]  = mode_halt;
    stat_q[10] = mode_sleep;
    ctl_q      = ctl;
  end

  AST_BUSOFF_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oper && bus_off && ctl.recov == REC_AUTO_HALT) |=> mode_halt); // R6

  AST_BUSOFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oper && bus_off && ctl.recov != REC_AUTO_HALT && !ctl_wr_en &&
     ctl.mode == MF_OPER) |=> mode_oper); // R6

endmodule

// File: tb/sim_can_mode_ctrl.sv
module sim_can_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 24;
  localparam int NV = 16;

  typedef struct packed {
    logic        wr;
    logic [15:0] wd;
    logic        idle;
    logic        boff;
    logic [3:0]  wt;
    logic [15:0] est;
    logic [15:0] ectl;
    logic [3:0]  req;
  } vec_t;

  // write, data, bus_idle, bus_off, extra edges, expected status, expected control, requirement
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0100, 1'b1, 1'b0, 4'd0, 16'h0400, 16'h0100, 4'd2}, // R2 not yet out of sleep
    '{1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 16'h0100, 16'h0100, 4'd2}, // R2 now in reset
    '{1'b1, 16'h090F, 1'b1, 1'b0, 4'd0, 16'h0100, 16'h090F, 4'd7}, // R7 writable in reset
    '{1'b1, 16'h0803, 1'b1, 1'b0, 4'd3, 16'h0100, 16'h0803, 4'd5}, // R5 one edge early
    '{1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 16'h0000, 16'h0803, 4'd5}, // R5 operation reached
    '{1'b1, 16'h0000, 1'b1, 1'b0, 4'd0, 16'h0000, 16'h0803, 4'd7}, // R7 locked in operation
    '{1'b1, 16'h0403, 1'b1, 1'b0, 4'd1, 16'h0000, 16'h0803, 4'd8}, // R8 sleep dropped
    '{1'b1, 16'h0903, 1'b0, 1'b0, 4'd3, 16'h0000, 16'h0903, 4'd4}, // R4 waits for idle
    '{1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 16'h0100, 16'h0903, 4'd4}, // R4 idle completes
    '{1'b1, 16'h0803, 1'b1, 1'b0, 4'd4, 16'h0000, 16'h0803, 4'd5}, // R5
    '{1'b0, 16'h0000, 1'b1, 1'b1, 4'd0, 16'h0200, 16'h0A03, 4'd6}, // R6 auto halt
    '{1'b1, 16'h0E03, 1'b1, 1'b0, 4'd1, 16'h0400, 16'h0E03, 4'd8}, // R8 halt to sleep
    '{1'b1, 16'h0203, 1'b1, 1'b0, 4'd1, 16'h0100, 16'h0A03, 4'd2}, // R2 wake to reset
    '{1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 16'h0200, 16'h0A03, 4'd4}, // R4 halt reached
    '{1'b1, 16'h0B03, 1'b0, 1'b0, 4'd1, 16'h0200, 16'h0B03, 4'd3}, // R3 one edge early
    '{1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 16'h0100, 16'h0B03, 4'd3}  // R3 forced reset done
  };

  logic             clk, rst_n;
  logic             ctl_wr_en, cfg_wr_en, bus_idle, bus_off;
  logic [15:0]      ctl_wr_data, ctl_q, stat_q;
  logic [CFG_W-1:0] cfg_wr_data, cfg_q;
  logic             mode_sleep, mode_reset, mode_halt, mode_oper;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  can_mode_ctrl #(.CFG_W(CFG_W), .FORCE_DLY(2), .OPER_DLY(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .bus_idle(bus_idle), .bus_off(bus_off),
    .ctl_q(ctl_q), .stat_q(stat_q), .cfg_q(cfg_q),
    .mode_sleep(mode_sleep), .mode_reset(mode_reset),
    .mode_halt(mode_halt), .mode_oper(mode_oper)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [15:0] wd, input logic idle,
                      input logic boff, input int wt);
    ctl_wr_en = wr; ctl_wr_data = wd; bus_idle = idle; bus_off = boff;
    @(posedge clk);
    @(negedge clk);
    ctl_wr_en = 1'b0; bus_off = 1'b0;
    repeat (wt) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [CFG_W-1:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0; cfg_wr_en = 1'b0;
    cfg_wr_data = '0; bus_idle = 1'b1; bus_off = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", 32'(ctl_q), 32'h0500);
    chk("R1 status", 32'(stat_q), 32'h0400);
    chk("R1 cfg", 32'(cfg_q), 32'h0);
    chk("R9 modes at reset", {28'h0, mode_sleep, mode_reset, mode_halt, mode_oper}, 32'h8);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].wd, VECS[i].idle, VECS[i].boff, int'(VECS[i].wt));
      chk($sformatf("R%0d vec%0d status", VECS[i].req, i), 32'(stat_q), 32'(VECS[i].est));
      chk($sformatf("R%0d vec%0d ctl", VECS[i].req, i), 32'(ctl_q), 32'(VECS[i].ectl));
    end

    // R7 configuration accepted in reset
    cfg_write(24'h123456);
    chk("R7 cfg write in reset", 32'(cfg_q), 32'h123456);
    // recovery field 00, go to operation
    step(1'b1, 16'h0003, 1'b1, 1'b0, 4);
    chk("R5 operation after delay", 32'(stat_q), 32'h0);
    chk("R9 modes in operation", {28'h0, mode_sleep, mode_reset, mode_halt, mode_oper}, 32'h1);
    // R7 configuration locked outside reset
    cfg_write(24'hABCDEF);
    chk("R7 cfg locked", 32'(cfg_q), 32'h123456);
    // R6 bus-off ignored without auto-halt recovery
    step(1'b0, 16'h0000, 1'b1, 1'b1, 1);
    chk("R6 bus-off ignored status", 32'(stat_q), 32'h0);
    chk("R6 bus-off ignored ctl", 32'(ctl_q), 32'h0003);
    // R3 forced reset from operation with a busy bus
    step(1'b1, 16'h0303, 1'b0, 1'b0, 1);
    chk("R3 forced reset early", {31'h0, mode_oper}, 32'h1);
    @(negedge clk);
    chk("R3 forced reset done", 32'(stat_q), 32'h0100);
    chk("R9 modes in reset", {28'h0, mode_sleep, mode_reset, mode_halt, mode_oper}, 32'h4);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule